// File: doc/BRIEF.md
# Posted-Write Ordering Bridge Controller

This controller sits between a host port and a shared parallel bus. Host writes are posted. The host sees each write complete at once, and the write waits in a small first-in first-out buffer. The controller offers the oldest buffered write to a bus target. The target either accepts it or answers retry. A write that is retried stays at the head of the buffer and is offered again. It is never dropped or passed by a later write.

Bus masters also start transactions toward host memory through an inbound request port. The controller answers each request in the same cycle with accept or retry. An inbound read gets retry while any posted host write is still waiting, so the read cannot overtake that write. An inbound write takes one of a fixed number of inbound buffers. These buffers drain toward memory at a fixed pace, and a write that finds them all occupied gets retry. Either rule can starve a master. For this reason the controller counts consecutive retries for each master and raises a per-master timeout flag when the count passes a limit. The master that was retried must reissue its own request.

Top module: `bridge_order_ctrl`

## Requirements
- R1: `hst_ready` is high while fewer than DEPTH (default 4) posted writes are held, and low once DEPTH writes are held and none has left.
- R2: `ob_req` is high exactly while a posted write is held. `ob_addr`/`ob_data` show the oldest one, and writes leave in the order the host issued them.
- R3: When the target answers `ob_retry`, the same write is offered again in the next cycle. Only `ob_ack` removes it.
- R4: An inbound read (`ib_write`=0) is answered with retry in every cycle in which `ob_req` is high. In a cycle with no posted write held, it is accepted.
- R5: An inbound write (`ib_write`=1) is accepted while fewer than NWBUF (default 2) inbound buffers are occupied, and retried otherwise.
- R6: Occupied inbound buffers free one entry every DRAIN (default 8) cycles. After two writes are accepted on consecutive edges, a write retried on every following cycle is accepted on its eighth attempt.
- R7: In every cycle with `ib_req` high, exactly one of `ib_accept`/`ib_retry` is high. With `ib_req` low, both are low.
- R8: `ib_retry_cnt` shows, for the master on `ib_master`, how many times in a row its requests have been retried. An accept clears it, and each master has its own count.
- R9: `ib_timeout[m]` goes high after master m has been retried more than LIMIT (default 256) times in a row, and goes low one cycle after that master is accepted.
- R10: After reset, `hst_ready` is high, and `ob_req`, `ib_timeout`, `ib_accept` and `ib_retry` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host write request |
| hst_ready | output | 1 | Posted-write buffer has room |
| hst_addr | input | AW | Host write address |
| hst_data | input | DW | Host write data |
| ob_req | output | 1 | Posted write offered to the bus target |
| ob_addr | output | AW | Address of the offered write |
| ob_data | output | DW | Data of the offered write |
| ob_ack | input | 1 | Target accepts the offered write |
| ob_retry | input | 1 | Target asks for the write to be retried |
| ib_req | input | 1 | Inbound request from a bus master |
| ib_write | input | 1 | 1 = inbound write, 0 = inbound read |
| ib_master | input | MW | Identifier of the requesting master |
| ib_accept | output | 1 | Inbound request completes |
| ib_retry | output | 1 | Inbound request must be reissued |
| ib_retry_cnt | output | CW | Consecutive retries of the requesting master |
| ib_timeout | output | NMASTER | Per-master starvation flag |

## Verification
The inbound answer, `ib_retry_cnt` and `hst_ready` are combinational from registered state. The bench drives stimulus at the falling edge and reads these outputs 1 ns later, in the same cycle. A host write, an `ob_ack`, an inbound write and a drain step each change state at the next rising edge. Effects on `ob_req`, buffer room and `ib_timeout` are therefore checked on the attempt after that edge. For the drain, the bench counts attempts and expects the eighth to be accepted. A scoreboard queue collects host writes in the order they were issued. The target model compares the head of the queue in every cycle it acknowledges, and compares nothing in the cycles it retries.

// File: rtl/bo_pkg.sv
package bo_pkg;
  // answer given to an inbound bus-master request
  typedef enum logic [1:0] {
    IB_IDLE   = 2'd0,
    IB_ACCEPT = 2'd1,
    IB_RETRY  = 2'd2
  } ib_resp_e;
endpackage

// File: rtl/bo_post_fifo.sv
module bo_post_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem[rp_q];

  always_comb begin
    wp_n  = push ? bump(wp_q) : wp_q;
    rp_n  = pop  ? bump(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/bo_ib_wbuf.sv
module bo_ib_wbuf #(
  parameter int NWBUF = 2,
  parameter int DRAIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic room
);
  localparam int OW = $clog2(NWBUF + 1);
  localparam int TW = $clog2(DRAIN + 1);

  logic [OW-1:0] occ_q, occ_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic          drain;

  assign room  = (occ_q < OW'(NWBUF));
  assign drain = (occ_q != '0) && (tmr_q == TW'(DRAIN - 1));

  always_comb begin
    tmr_n = ((occ_q == '0) || drain) ? '0 : tmr_q + 1'b1;
    occ_n = occ_q + OW'(take) - OW'(drain);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      tmr_q <= '0;
    end else begin
      occ_q <= occ_n;
      tmr_q <= tmr_n;
    end
  end
endmodule

// File: rtl/bo_retry_track.sv
module bo_retry_track #(
  parameter int NMASTER = 4,
  parameter int LIMIT   = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic [$clog2(NMASTER)-1:0] master,
  input  logic                       accept,
  input  logic                       retry,
  output logic [$clog2(LIMIT+2)-1:0] cnt_sel,
  output logic [NMASTER-1:0]         timeout
);
  localparam int CW  = $clog2(LIMIT + 2);
  localparam int MW  = $clog2(NMASTER);
  localparam int SAT = LIMIT + 1;

  logic [CW-1:0] cnt_q [NMASTER];
  logic [CW-1:0] cnt_n [NMASTER];

  for (genvar g = 0; g < NMASTER; g++) begin : g_mst
    logic hit;
    assign hit = req && (master == MW'(g));

    always_comb begin
      cnt_n[g] = cnt_q[g];
      if (hit && accept)
        cnt_n[g] = '0;
      else if (hit && retry && (cnt_q[g] != CW'(SAT)))
        cnt_n[g] = cnt_q[g] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[g] <= '0;
      else        cnt_q[g] <= cnt_n[g];
    end

    assign timeout[g] = (cnt_q[g] > CW'(LIMIT));
  end

  assign cnt_sel = cnt_q[master];
endmodule

// File: rtl/bridge_order_ctrl.sv
module bridge_order_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int DEPTH   = 4,
  parameter int NWBUF   = 2,
  parameter int DRAIN   = 8,
  parameter int NMASTER = 4,
  parameter int LIMIT   = 256,
  localparam int MW     = $clog2(NMASTER),
  localparam int CW     = $clog2(LIMIT + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_valid,
  output logic               hst_ready,
  input  logic [AW-1:0]      hst_addr,
  input  logic [DW-1:0]      hst_data,
  output logic               ob_req,
  output logic [AW-1:0]      ob_addr,
  output logic [DW-1:0]      ob_data,
  input  logic               ob_ack,
  input  logic               ob_retry,
  input  logic               ib_req,
  input  logic               ib_write,
  input  logic [MW-1:0]      ib_master,
  output logic               ib_accept,
  output logic               ib_retry,
  output logic [CW-1:0]      ib_retry_cnt,
  output logic [NMASTER-1:0] ib_timeout
);
  import bo_pkg::*;

  localparam int EW = AW + DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // posted host writes
  logic          pf_empty, pf_full, pf_push, pf_pop;
  logic [EW-1:0] pf_head;

  assign hst_ready = !pf_full;
  assign pf_push   = hst_valid && !pf_full;
  assign pf_pop    = !pf_empty && ob_ack;

  bo_post_fifo #(.DEPTH(DEPTH), .W(EW)) u_post (
    .clk   (clk),
    .rst_n (rst_core_n),
    .push  (pf_push),
    .pop   (pf_pop),
    .din   ({hst_addr, hst_data}),
    .dout  (pf_head),
    .empty (pf_empty),
    .full  (pf_full)
  );

  assign ob_req  = !pf_empty;
  assign ob_addr = pf_head[EW-1:DW];
  assign ob_data = pf_head[DW-1:0];

  // inbound ordering and buffer decision
  logic     wb_room;
  ib_resp_e resp;

  always_comb begin
    resp = IB_IDLE;
    if (ib_req) begin
      if (ib_write) resp = wb_room  ? IB_ACCEPT : IB_RETRY;
      else          resp = pf_empty ? IB_ACCEPT : IB_RETRY;
    end
  end

  assign ib_accept = (resp == IB_ACCEPT);
  assign ib_retry  = (resp == IB_RETRY);

  bo_ib_wbuf #(.NWBUF(NWBUF), .DRAIN(DRAIN)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_core_n),
    .take  (ib_accept && ib_write),
    .room  (wb_room)
  );

  bo_retry_track #(.NMASTER(NMASTER), .LIMIT(LIMIT)) u_track (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .req     (ib_req),
    .master  (ib_master),
    .accept  (ib_accept),
    .retry   (ib_retry),
    .cnt_sel (ib_retry_cnt),
    .timeout (ib_timeout)
  );
endmodule

// File: rtl/bridge_order_ctrl_chk.sv
module bridge_order_ctrl_chk #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int NMASTER = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hst_ready,
  input logic               ob_req,
  input logic [AW-1:0]      ob_addr,
  input logic [DW-1:0]      ob_data,
  input logic               ob_retry,
  input logic               ib_req,
  input logic               ib_write,
  input logic               ib_accept,
  input logic               ib_retry,
  input logic [NMASTER-1:0] ib_timeout
);
  assert_read_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_accept && !ib_write) |-> !ob_req);

  assert_one_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> ($countones({ib_accept, ib_retry}) == 1));

  assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_req |-> (!ib_accept && !ib_retry));

  assert_hold_on_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_req && ob_retry) |=> (ob_req && $stable(ob_addr) && $stable(ob_data)));

  assert_stall_needs_backlog_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_ready |-> ob_req);

  assert_timeout_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|ib_timeout) |-> $past(ib_retry));
endmodule

bind bridge_order_ctrl bridge_order_ctrl_chk #(.AW(AW), .DW(DW), .NMASTER(NMASTER)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hst_ready  (hst_ready),
  .ob_req     (ob_req),
  .ob_addr    (ob_addr),
  .ob_data    (ob_data),
  .ob_retry   (ob_retry),
  .ib_req     (ib_req),
  .ib_write   (ib_write),
  .ib_accept  (ib_accept),
  .ib_retry   (ib_retry),
  .ib_timeout (ib_timeout)
);

// File: tb/test_bridge_order_ctrl.sv
`timescale 1ns/1ps
module test_bridge_order_ctrl;
  localparam int AW = 16, DW = 32, NM = 4, LIMIT = 256;
  localparam int MW = $clog2(NM);
  localparam int CW = $clog2(LIMIT + 2);

  logic clk = 0, rst_n = 0;
  logic hst_valid = 0, ob_ack = 0, ob_retry = 0;
  logic ib_req = 0, ib_write = 0;
  logic [AW-1:0] hst_addr = '0;
  logic [DW-1:0] hst_data = '0;
  logic [MW-1:0] ib_master = '0;
  logic hst_ready, ob_req, ib_accept, ib_retry;
  logic [AW-1:0] ob_addr;
  logic [DW-1:0] ob_data;
  logic [CW-1:0] ib_retry_cnt;
  logic [NM-1:0] ib_timeout;

  always #2.5 clk = ~clk;

  bridge_order_ctrl i_bridge_order_ctrl (.*);

  int n_chk = 0, n_bad = 0;
  logic [AW+DW-1:0] exp_q [$];
  bit   tgt_block = 1;
  int   tgt_each = 0, tgt_hold = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model and scoreboard monitor (R2, R3)
  always @(negedge clk) begin
    ob_ack = 0; ob_retry = 0;
    #1;
    if (ob_req) begin
      if (tgt_block || tgt_hold > 0) begin
        ob_retry = 1;
        if (!tgt_block) tgt_hold--;
      end else begin
        ob_ack = 1;
        if (exp_q.size() == 0) chk(0, "R2 unexpected write", 64'(ob_addr), 0);
        else begin
          chk({ob_addr, ob_data} == exp_q[0], "R2/R3 order", 64'({ob_addr, ob_data}), 64'(exp_q[0]));
          void'(exp_q.pop_front());
        end
        tgt_hold = tgt_each;
      end
    end
  end

  task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); hst_valid = 1; hst_addr = a; hst_data = d; #1;
    while (!hst_ready) begin @(negedge clk); #1; end
    exp_q.push_back({a, d});
    @(posedge clk); #1 hst_valid = 0;
  endtask

  task automatic ib_try(input logic w, input logic [MW-1:0] m,
                        output logic acc, output logic ret, output logic [CW-1:0] cnt);
    @(negedge clk); ib_req = 1; ib_write = w; ib_master = m; #1.5;
    acc = ib_accept; ret = ib_retry; cnt = ib_retry_cnt;
    @(posedge clk); #1 ib_req = 0;
  endtask

  initial begin
    #(5ns * 150000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a, r; logic [CW-1:0] c; int tries;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R10 reset state, R7 idle
    chk(hst_ready === 1'b1, "R10 ready", 64'(hst_ready), 1);
    chk(ob_req === 1'b0, "R10 ob_req", 64'(ob_req), 0);
    chk(ib_timeout === '0, "R10 timeout", 64'(ib_timeout), 0);
    chk(!ib_accept && !ib_retry, "R7 idle", 64'({ib_accept, ib_retry}), 0);

    // R1: fill posted buffer with target blocked
    for (int i = 0; i < 4; i++) host_wr(AW'(16'h100 + i), DW'(32'hA000 + i));
    @(negedge clk); #1;
    chk(!hst_ready, "R1 full stall", 64'(hst_ready), 0);
    chk(ob_req, "R2 pending", 64'(ob_req), 1);

    // R4 reads retried while pending, R8 counting
    for (int i = 0; i < 3; i++) begin
      ib_try(0, 2'd1, a, r, c);
      chk(r && !a, "R4 read retried", 64'({a, r}), 1);
      chk(c == CW'(i), "R8 count", 64'(c), 64'(i));
    end

    // R2/R3: release with 2 retries per write; scoreboard checks order
    tgt_each = 2; tgt_hold = 2; tgt_block = 0;
    host_wr(16'h200, 32'hBEEF);
    wait (exp_q.size() == 0);
    @(posedge clk);
    ib_try(0, 2'd1, a, r, c);
    chk(a && !r, "R4 read after drain", 64'({a, r}), 2);
    chk(c == 3, "R8 count before accept", 64'(c), 3);
    ib_try(0, 2'd1, a, r, c);
    chk(c == 0, "R8 cleared", 64'(c), 0);

    // R5/R6 inbound write buffers
    ib_try(1, 2'd2, a, r, c);
    chk(a, "R5 first write", 64'(a), 1);
    ib_try(1, 2'd2, a, r, c);
    chk(a, "R5 second write", 64'(a), 1);
    tries = 0;
    do begin ib_try(1, 2'd2, a, r, c); tries++; end while (!a && tries < 40);
    chk(tries == 8, "R6 drain pace", 64'(tries), 8);
    chk(c == 7, "R8 write retries", 64'(c), 7);

    // R9 timeout
    tgt_block = 1;
    host_wr(16'h300, 32'h1234);
    for (int i = 0; i < LIMIT; i++) ib_try(0, 2'd3, a, r, c);
    @(negedge clk); #1;
    chk(ib_timeout == '0, "R9 not yet", 64'(ib_timeout), 0);
    ib_try(0, 2'd3, a, r, c);
    @(negedge clk); #1;
    chk(ib_timeout == 4'b1000, "R9 raised", 64'(ib_timeout), 8);
    ib_master = 2'd1; #0.5;
    chk(ib_retry_cnt == 0, "R8 per master", 64'(ib_retry_cnt), 0);
    tgt_block = 0; tgt_each = 0; tgt_hold = 0;
    wait (exp_q.size() == 0);
    @(posedge clk);
    ib_try(0, 2'd3, a, r, c);
    chk(a, "R9 accept after starve", 64'(a), 1);
    @(negedge clk); #1;
    chk(ib_timeout == '0, "R9 cleared", 64'(ib_timeout), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule